// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is a single down-counting timer with a small word-addressed register bank. Software writes a start value, picks a counting mode, a tick divider, a counter width and whether the expiry interrupt reaches the pin, and then sets the run bit. Each divided tick lowers the count by one. When the count runs out, the block latches an interrupt flag. It then reloads, wraps or parks, depending on the mode.

Three modes are available. Free-running wraps to the all-ones value of the selected width. Periodic reloads from a stored limit. One-shot parks at zero. A second write path can change the stored limit without touching the live count, so the new period takes effect at the next reload. Reads return their data in the same cycle. Writes take effect at the next clock edge.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control word reads 0x20 (interrupt enable only, stopped, 16-bit, free-running), the value reads 0xFFFF, the limit (word 0) reads 0, the raw flag reads 0 and `irq_o` is low.
- R2: The count changes only while control bit 7 (run) is set, or on a write to word 0. Any control write (word 2) keeps the count unchanged on its own clock edge, and counting then continues from the held value if the run bit is still set.
- R3: Control bits [3:2] select the tick divider: 0 gives 1, 1 gives 16, 2 gives 256 and 3 gives 1. A write to word 0 or word 2 restarts the divider phase, so the first decrement lands exactly divider cycles after that write edge.
- R4: In free-running mode (bit 6 clear, bit 0 clear), a tick at count 1 or 0 reloads 0xFFFF when bit 1 is clear, or 0xFFFFFFFF when bit 1 is set, and counts as an expiry.
- R5: In periodic mode (bit 6 set, bit 0 clear), a tick at count 1 or 0 reloads the limit and counts as an expiry, so a limit of L expires every L ticks.
- R6: In one-shot mode (bit 0 set, which takes priority over bit 6), a tick at count 1 moves to 0 and counts as an expiry. At 0 the count stays parked and raises no further expiry.
- R7: A write to word 0 sets the limit and the count together and restarts the divider. Word 0 reads back the limit.
- R8: A write to word 6 sets only the limit, leaves the running count alone, and is used at the next reload. Word 6 reads back the limit.
- R9: Every expiry sets the raw flag, which reads back as bit 0 of word 4. Word 5 and `irq_o` equal the raw flag ANDed with control bit 5.
- R10: A write of any data to word 3 clears the raw flag. An expiry in the same cycle wins.
- R11: Writes to words 1, 4 and 5 have no effect. Reads of word 3 and word 7 return 0.
- R12: With control bit 1 clear, only the low 16 bits of the count are used and read back. The upper bits of a loaded value are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when set together with `req_i` |
| addr_i | input | ADDR_W | Byte offset; word index is `addr_i >> 2` |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt: raw flag AND enable bit |

## Verification
The bench builds the block with its default parameters: a 32-bit counter with a 16-bit narrow mode and dividers of 16 and 256. Because the start values are kept small, every divider setting can be swept against several loads and tick counts. Each sweep includes the tick counts just before, exactly at and just past an expiry. The 16-bit and 32-bit wraps are reached from start values of 2 or 3. The divider phase is checked by sampling one cycle before each expected tick, so a tick that arrives early or late changes the value read back.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CTRL_W     = 8;
  localparam int B_ONESHOT  = 0;
  localparam int B_WIDE     = 1;
  localparam int B_PRE_LO   = 2;
  localparam int B_IE       = 5;
  localparam int B_PERIODIC = 6;
  localparam int B_RUN      = 7;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  typedef enum logic [2:0] {
    W_LOAD   = 3'd0,
    W_VALUE  = 3'd1,
    W_CTRL   = 3'd2,
    W_ICLR   = 3'd3,
    W_RAW    = 3'd4,
    W_MASKED = 3'd5,
    W_BGLOAD = 3'd6
  } word_e;

  typedef enum logic [1:0] {
    M_FREE     = 2'd0,
    M_PERIODIC = 2'd1,
    M_ONESHOT  = 2'd2
  } mode_e;

  typedef struct packed {
    logic       run;
    logic       ie;
    logic       wide;
    logic [1:0] pre_sel;
    mode_e      mode;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(logic [CTRL_W-1:0] c);
    ctrl_t d;
    d.run     = c[B_RUN];
    d.ie      = c[B_IE];
    d.wide    = c[B_WIDE];
    d.pre_sel = c[B_PRE_LO+1:B_PRE_LO];
    if (c[B_ONESHOT])       d.mode = M_ONESHOT;
    else if (c[B_PERIODIC]) d.mode = M_PERIODIC;
    else                    d.mode = M_FREE;
    return d;
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int DIV_A_LOG2 = 4,
  parameter int DIV_B_LOG2 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clear_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [DIV_B_LOG2-1:0] ph_q;
  logic                  wrap_a, wrap_b, raw_tick;

  assign wrap_a = &ph_q[DIV_A_LOG2-1:0];
  assign wrap_b = &ph_q;

  always_comb begin
    unique case (sel_i)
      2'd1:    raw_tick = wrap_a;
      2'd2:    raw_tick = wrap_b;
      default: raw_tick = 1'b1;
    endcase
  end

  // A register write restarts the phase and swallows the tick of its edge
  assign tick_o = run_i & ~clear_i & raw_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (clear_i) ph_q <= '0;
    else if (run_i)   ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter import cdt_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  mode_e             mode_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] limit_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE         = DATA_W'(1);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});

  logic [DATA_W-1:0] cnt_q, cnt_d, mask, eff, reload;
  logic              at_end;

  assign mask    = wide_i ? '1 : NARROW_MASK;
  assign eff     = cnt_q & mask;
  assign reload  = (mode_i == M_PERIODIC) ? (limit_i & mask) : mask;
  assign at_end  = (eff <= ONE);
  assign count_o = eff;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      if (mode_i == M_ONESHOT) begin
        if (eff == ONE) begin
          cnt_d    = '0;
          expire_o = 1'b1;
        end else if (eff != '0) begin
          cnt_d = eff - ONE;
        end
      end else if (at_end) begin
        cnt_d    = reload;
        expire_o = 1'b1;
      end else begin
        cnt_d = eff - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs import cdt_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic [DATA_W-1:0] count_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] limit_o,
  output logic              load_wr_o,
  output logic              ctrl_wr_o,
  output logic              iclr_wr_o,
  output logic              raw_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              wr, bg_wr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] limit_q;
  logic              raw_q;

  assign word      = addr_i[ADDR_W-1:2];
  assign wr        = req_i & we_i;
  assign load_wr_o = wr & (word == WORD_W'(W_LOAD));
  assign ctrl_wr_o = wr & (word == WORD_W'(W_CTRL));
  assign iclr_wr_o = wr & (word == WORD_W'(W_ICLR));
  assign bg_wr     = wr & (word == WORD_W'(W_BGLOAD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RESET;
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (ctrl_wr_o)           ctrl_q  <= wdata_i[CTRL_W-1:0];
      if (load_wr_o || bg_wr)  limit_q <= wdata_i;
      if (expire_i)            raw_q   <= 1'b1;
      else if (iclr_wr_o)      raw_q   <= 1'b0;
    end
  end

  assign ctrl_o  = decode_ctrl(ctrl_q);
  assign limit_o = limit_q;
  assign raw_o   = raw_q;
  assign irq_o   = raw_q & ctrl_o.ie;

  always_comb begin
    rdata_o = '0;
    if (word == WORD_W'(W_LOAD) || word == WORD_W'(W_BGLOAD)) rdata_o = limit_q;
    else if (word == WORD_W'(W_VALUE))  rdata_o = count_i;
    else if (word == WORD_W'(W_CTRL))   rdata_o = DATA_W'(ctrl_q);
    else if (word == WORD_W'(W_RAW))    rdata_o = DATA_W'(raw_q);
    else if (word == WORD_W'(W_MASKED)) rdata_o = DATA_W'(irq_o);
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer import cdt_pkg::*; #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int NARROW_W   = 16,
  parameter int DIV_A_LOG2 = 4,
  parameter int DIV_B_LOG2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] limit, count_eff;
  logic              load_wr, ctrl_wr, iclr_wr, raw_flag, tick, expire;
  logic              run, ie, wide, oneshot;

  assign run     = ctrl.run;
  assign ie      = ctrl.ie;
  assign wide    = ctrl.wide;
  assign oneshot = (ctrl.mode == M_ONESHOT);

  cdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .expire_i(expire),
    .count_i(count_eff), .ctrl_o(ctrl), .limit_o(limit),
    .load_wr_o(load_wr), .ctrl_wr_o(ctrl_wr), .iclr_wr_o(iclr_wr),
    .raw_o(raw_flag), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  cdt_prescaler #(.DIV_A_LOG2(DIV_A_LOG2), .DIV_B_LOG2(DIV_B_LOG2)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .clear_i(ctrl_wr | load_wr), .sel_i(ctrl.pre_sel), .tick_o(tick)
  );

  cdt_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .load_i(load_wr),
    .load_val_i(wdata_i), .mode_i(ctrl.mode), .wide_i(wide),
    .limit_i(limit), .count_o(count_eff), .expire_o(expire)
  );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              ie,
  input logic              run,
  input logic              oneshot,
  input logic              raw_flag,
  input logic              expire,
  input logic              tick,
  input logic              load_wr,
  input logic              ctrl_wr,
  input logic              iclr_wr,
  input logic [DATA_W-1:0] count_eff
);
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie && raw_flag));

  assert_expiry_latches_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> raw_flag);

  assert_clear_drops_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iclr_wr && !expire) |=> !raw_flag);

  assert_hold_when_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load_wr && !ctrl_wr) |=> $stable(count_eff));

  assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && count_eff > DATA_W'(1)) |=> (count_eff == $past(count_eff) - DATA_W'(1)));

  assert_write_swallows_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr || load_wr) |-> !tick);

  assert_oneshot_parks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oneshot && count_eff == '0 && !load_wr && !ctrl_wr) |=> (count_eff == '0 && !expire));
endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .ie(ie), .run(run),
  .oneshot(oneshot), .raw_flag(raw_flag), .expire(expire), .tick(tick),
  .load_wr(load_wr), .ctrl_wr(ctrl_wr), .iclr_wr(iclr_wr),
  .count_eff(count_eff)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  localparam logic [31:0] C_ONE = 32'h01, C_WIDE = 32'h02, C_IE = 32'h20,
                          C_PER = 32'h40, C_RUN = 32'h80;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  cdt_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; consumes exactly one rising edge
  task automatic wr(input int w, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = 5'(w << 2); wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    addr_i = 5'(w << 2);
    #1;
    d = rdata_o;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [31:0] load, input logic [31:0] ctrl);
    wr(2, 32'h0);
    wr(3, 32'h0);
    wr(0, load);
    wr(2, ctrl);
  endtask

  function automatic logic [31:0] exp_wrap(longint c, longint t, longint m);
    longint v;
    v = (c - 1 - t) % m;
    if (v < 0) v += m;
    return 32'(v + 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lens[3] = '{1, 3, 7};

    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state
    rd(2, d); chk("R1 ctrl", d, 32'h20);
    rd(1, d); chk("R1 value", d, 32'hFFFF);
    rd(0, d); chk("R1 limit", d, 32'h0);
    rd(4, d); chk("R1 raw", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    step(10);
    rd(1, d); chk("R2 stopped hold", d, 32'hFFFF);

    // R3/R5/R9 periodic sweep across every divider code
    for (int sel = 0; sel < 4; sel++) begin
      for (int li = 0; li < 3; li++) begin
        for (int ti = 0; ti < 4; ti++) begin
          int dv, l, t;
          dv = (sel == 1) ? 16 : (sel == 2) ? 256 : 1;
          l  = lens[li];
          t  = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? l : l + 2;
          restart(32'(l), C_RUN | C_PER | C_IE | C_WIDE | 32'(sel << 2));
          step(t * dv + dv - 1);
          rd(1, d); chk($sformatf("R5 R3 periodic sel%0d L%0d t%0d", sel, l, t), d, 32'(l - (t % l)));
          rd(4, d); chk("R9 raw after periodic", d, {31'b0, t >= l});
          chk("R9 irq", {31'b0, irq_o}, {31'b0, t >= l});
        end
      end
    end

    // R4 free-running 16-bit wrap
    for (int ti = 0; ti < 4; ti++) begin
      int t;
      t = (ti == 0) ? 2 : (ti == 1) ? 3 : (ti == 2) ? 4 : 6;
      restart(32'd3, C_RUN | C_IE);
      step(t);
      rd(1, d); chk($sformatf("R4 free16 t%0d", t), d, exp_wrap(3, t, 65535));
      rd(4, d); chk("R4 free16 raw", d, {31'b0, t >= 3});
    end
    // R4 free-running 32-bit wrap
    for (int t = 2; t < 4; t++) begin
      restart(32'd2, C_RUN | C_WIDE);
      step(t);
      rd(1, d); chk($sformatf("R4 free32 t%0d", t), d, exp_wrap(2, t, 64'hFFFF_FFFF));
    end

    // R12 narrow mode ignores upper load bits
    wr(2, 32'h0); wr(3, 32'h0); wr(0, 32'h0001_0005);
    rd(1, d); chk("R12 narrow read", d, 32'h5);
    wr(2, C_RUN);
    step(5);
    rd(1, d); chk("R12 narrow wrap", d, 32'hFFFF);
    rd(4, d); chk("R12 narrow expiry", d, 32'h1);

    // R6 one-shot (bit 6 also set: one-shot wins)
    for (int ti = 0; ti < 3; ti++) begin
      int t;
      t = (ti == 0) ? 3 : (ti == 1) ? 4 : 10;
      restart(32'd4, C_RUN | C_ONE | C_PER | C_IE | C_WIDE);
      step(t);
      rd(1, d); chk($sformatf("R6 oneshot t%0d", t), d, (t >= 4) ? 32'h0 : 32'(4 - t));
      rd(4, d); chk("R6 oneshot raw", d, {31'b0, t >= 4});
    end
    wr(3, 32'h0);
    step(5);
    rd(4, d); chk("R6 no refire", d, 32'h0);
    rd(1, d); chk("R6 parked", d, 32'h0);

    // R8 background load
    restart(32'd5, C_RUN | C_PER | C_WIDE);
    step(2);
    wr(6, 32'd2);
    rd(1, d); chk("R8 count undisturbed", d, 32'd2);
    rd(0, d); chk("R8 limit via word0", d, 32'd2);
    rd(6, d); chk("R8 limit via word6", d, 32'd2);
    step(2);
    rd(1, d); chk("R8 new reload", d, 32'd2);
    rd(4, d); chk("R8 expiry", d, 32'h1);
    step(2);
    rd(1, d); chk("R8 next period", d, 32'd2);

    // R2 pause on control writes
    restart(32'd100, C_RUN | C_PER | C_WIDE);
    step(10);
    rd(1, d); chk("R2 running", d, 32'd90);
    wr(2, C_PER | C_WIDE);
    step(20);
    rd(1, d); chk("R2 held while stopped", d, 32'd90);
    wr(2, C_RUN | C_PER | C_WIDE);
    step(5);
    rd(1, d); chk("R2 resume from held", d, 32'd85);
    wr(2, C_RUN | C_PER | C_WIDE);
    step(5);
    rd(1, d); chk("R2 rewrite pauses one edge", d, 32'd80);

    // R7 load while running
    restart(32'd10, C_RUN | C_PER | C_WIDE);
    step(3);
    rd(1, d); chk("R7 before load", d, 32'd7);
    wr(0, 32'd20);
    rd(1, d); chk("R7 immediate reload", d, 32'd20);
    rd(0, d); chk("R7 limit", d, 32'd20);
    step(4);
    rd(1, d); chk("R7 counts from load", d, 32'd16);

    // R9 enable gating
    restart(32'd2, C_RUN | C_PER | C_WIDE);
    step(3);
    rd(1, d); chk("R9 value", d, 32'd1);
    rd(4, d); chk("R9 raw without enable", d, 32'h1);
    rd(5, d); chk("R9 masked without enable", d, 32'h0);
    chk("R9 irq without enable", {31'b0, irq_o}, 32'h0);
    wr(2, C_PER | C_WIDE | C_IE);
    rd(5, d); chk("R9 masked with enable", d, 32'h1);
    chk("R9 irq with enable", {31'b0, irq_o}, 32'h1);

    // R11 ignored writes and empty words
    wr(1, 32'h55);
    rd(1, d); chk("R11 value write ignored", d, 32'd1);
    wr(4, 32'h0);
    wr(5, 32'h0);
    rd(4, d); chk("R11 status writes ignored", d, 32'h1);
    rd(3, d); chk("R11 word3 reads zero", d, 32'h0);
    rd(7, d); chk("R11 word7 reads zero", d, 32'h0);

    // R10 interrupt clear with arbitrary data
    wr(3, 32'hDEAD_BEEF);
    rd(4, d); chk("R10 raw cleared", d, 32'h0);
    chk("R10 irq cleared", {31'b0, irq_o}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule